// File: doc/BRIEF.md
# Multiplexed 3½-Digit Seven-Segment Display Scanner

This block drives a four-position multiplexed seven-segment LED display from the held result of a converter. The result arrives as three BCD digits, a half-digit bit for the leading "1", a polarity bit and an overflow flag. The block steps through the four digit positions one at a time. It begins each position with a short dark gap and then lights that position with its segment pattern. The scan runs from the converter's own clock, so the moments when digits switch always fall at fixed points of the conversion timing.

The leading half-digit position shows either a "1" (segments b and c) or nothing, so a leading zero never lights. When the overflow flag is set, the numeric digits are replaced by the letters O, F, L. The polarity indicator continues to follow the input, so the display reads as a plus or minus overflow. All value inputs are plain levels held by the upstream latch and are sampled on every clock. There is no handshake: the display always shows the most recently sampled value and never applies back-pressure.

Top module: `disp_mux_top`

## Requirements
- R1: While `rst_n` is low, `seg`, `dig_en` and `sign_led` are all 0, and the scan restarts at the leading position once reset is released.
- R2: Positions are scanned in the order `dig_en[3]` (half-digit), `dig_en[2]` (hundreds), `dig_en[1]` (tens), `dig_en[0]` (ones), then wrap. Each position owns 2^SLOT_LOG2 clock cycles. During the lit part of a slot exactly one `dig_en` bit is 1.
- R3: The first 2^SLOT_LOG2 / 2^BLANK_SHIFT cycles of every slot are dark: `dig_en` = 0 and `seg` = 0.
- R4: In the hundreds, tens and ones slots with overflow clear, `seg` shows the decoded digit. `seg[0]` is segment a and `seg[6]` is segment g, active high. The codes are 0=0x3F, 1=0x06, 2=0x5B, 3=0x4F, 4=0x66, 5=0x6D, 6=0x7D, 7=0x07, 8=0x7F, 9=0x6F.
- R5: A digit input with a value from 10 to 15 lights no segments in its slot, while its enable still follows R2.
- R6: With overflow clear, the half-digit slot shows 0x06 when `half_one` is 1. It shows 0x00 (leading zero suppressed) when `half_one` is 0.
- R7: With `ovf` set, the half-digit slot is dark (0x00). The hundreds, tens and ones slots show O (0x3F), F (0x71) and L (0x38), whatever the digit inputs are.
- R8: `sign_led` equals `sign_pos` (1 = positive) sampled at the previous clock edge. It is not scanned, and overflow does not change it.
- R9: All outputs are registered. Lit-slot contents reflect the inputs sampled at the same edge that updates the outputs.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter clock; the scan derives from it |
| rst_n | input | 1 | Asynchronous active-low reset |
| bcd_hund | input | 4 | Hundreds digit, BCD |
| bcd_tens | input | 4 | Tens digit, BCD |
| bcd_ones | input | 4 | Ones digit, BCD |
| half_one | input | 1 | Leading half-digit (1 = show "1") |
| sign_pos | input | 1 | Polarity, 1 = positive |
| ovf | input | 1 | Over-range flag |
| seg | output | 7 | Segments a..g in bits 0..6, active high |
| dig_en | output | 4 | Digit enables, bit 3 = half-digit, bit 0 = ones |
| sign_led | output | 1 | Polarity indicator |

## Verification
The assertions assume that reset is applied once before any check and that the value inputs meet synchronous timing. They place no limit on the value inputs themselves: any 4-bit code and any combination of the flags is legal. The bench keeps to this by changing inputs only on the falling clock edge. It draws digit codes from a full 4-bit pseudo-random sweep that includes the invalid codes 10 to 15, and it sets overflow in roughly one cycle in eight. It also applies a second asynchronous reset partway through a slot to check the restart.

// File: rtl/disp_pkg.sv
package disp_pkg;

  typedef logic [6:0] seg_t;

  typedef enum logic [2:0] {
    GL_DARK,
    GL_NUM,
    GL_ONE,
    GL_LET_O,
    GL_LET_F,
    GL_LET_L
  } glyph_kind_e;

  typedef struct packed {
    glyph_kind_e kind;
    logic [3:0]  value;
  } glyph_t;

  localparam seg_t SEG_ONE   = 7'h06;
  localparam seg_t SEG_LET_O = 7'h3F;
  localparam seg_t SEG_LET_F = 7'h71;
  localparam seg_t SEG_LET_L = 7'h38;
  localparam int   NUM_POS   = 4;

  function automatic seg_t bcd_pattern(input logic [3:0] v);
    seg_t p;
    case (v)
      4'd0: p = 7'h3F;
      4'd1: p = 7'h06;
      4'd2: p = 7'h5B;
      4'd3: p = 7'h4F;
      4'd4: p = 7'h66;
      4'd5: p = 7'h6D;
      4'd6: p = 7'h7D;
      4'd7: p = 7'h07;
      4'd8: p = 7'h7F;
      4'd9: p = 7'h6F;
      default: p = 7'h00;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/disp_scan_timer.sv
module disp_scan_timer #(
  parameter int SLOT_LOG2   = 8,
  parameter int BLANK_SHIFT = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic [1:0] slot,
  output logic       lit
);
  localparam int SLOT_CYC  = 1 << SLOT_LOG2;
  localparam int BLANK_CYC = SLOT_CYC >> BLANK_SHIFT;
  localparam int CW        = SLOT_LOG2 + 2;

  logic [CW-1:0]        cnt;
  logic [SLOT_LOG2-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  assign slot  = cnt[CW-1 -: 2];
  assign phase = cnt[SLOT_LOG2-1:0];

  generate
    if (BLANK_CYC == 0) begin : g_nogap
      assign lit = 1'b1;
    end else begin : g_gap
      assign lit = (int'(phase) >= BLANK_CYC);
    end
  endgenerate

  // R2: position advances by one (wrapping) after the last cycle of a slot
  a_r2_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(phase) == SLOT_CYC - 1) |=> (slot == $past(slot) + 2'd1));

  // R3: the slot's first cycle is always inside the dark gap
  a_r3_gap_first: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == '0 && BLANK_CYC > 0) |-> !lit);
endmodule

// File: rtl/disp_glyph_sel.sv
module disp_glyph_sel
  import disp_pkg::*;
(
  input  logic [1:0] slot,
  input  logic [3:0] bcd_hund,
  input  logic [3:0] bcd_tens,
  input  logic [3:0] bcd_ones,
  input  logic       half_one,
  input  logic       ovf,
  output glyph_t     glyph
);
  always_comb begin
    glyph = '{kind: GL_DARK, value: 4'd0};
    unique case (slot)
      2'd0: begin
        if (!ovf && half_one) glyph.kind = GL_ONE;
      end
      2'd1: begin
        if (ovf) glyph.kind = GL_LET_O;
        else     glyph = '{kind: GL_NUM, value: bcd_hund};
      end
      2'd2: begin
        if (ovf) glyph.kind = GL_LET_F;
        else     glyph = '{kind: GL_NUM, value: bcd_tens};
      end
      default: begin
        if (ovf) glyph.kind = GL_LET_L;
        else     glyph = '{kind: GL_NUM, value: bcd_ones};
      end
    endcase
  end
endmodule

// File: rtl/disp_seg_decode.sv
module disp_seg_decode
  import disp_pkg::*;
(
  input  glyph_t glyph,
  output seg_t   seg
);
  always_comb begin
    unique case (glyph.kind)
      GL_NUM:   seg = bcd_pattern(glyph.value);
      GL_ONE:   seg = SEG_ONE;
      GL_LET_O: seg = SEG_LET_O;
      GL_LET_F: seg = SEG_LET_F;
      GL_LET_L: seg = SEG_LET_L;
      default:  seg = 7'h00;
    endcase
  end
endmodule

// File: rtl/disp_mux_top.sv
module disp_mux_top
  import disp_pkg::*;
#(
  parameter int SLOT_LOG2   = 8,
  parameter int BLANK_SHIFT = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] bcd_hund,
  input  logic [3:0] bcd_tens,
  input  logic [3:0] bcd_ones,
  input  logic       half_one,
  input  logic       sign_pos,
  input  logic       ovf,
  output logic [6:0] seg,
  output logic [3:0] dig_en,
  output logic       sign_led
);
  logic [1:0] slot;
  logic       lit;
  glyph_t     glyph;
  seg_t       seg_c;
  logic [NUM_POS-1:0] en_c;
  logic       armed;

  disp_scan_timer #(.SLOT_LOG2(SLOT_LOG2), .BLANK_SHIFT(BLANK_SHIFT)) u_timer (
    .clk(clk), .rst_n(rst_n), .slot(slot), .lit(lit));

  disp_glyph_sel u_sel (
    .slot(slot), .bcd_hund(bcd_hund), .bcd_tens(bcd_tens), .bcd_ones(bcd_ones),
    .half_one(half_one), .ovf(ovf), .glyph(glyph));

  disp_seg_decode u_dec (.glyph(glyph), .seg(seg_c));

  generate
    for (genvar i = 0; i < NUM_POS; i++) begin : g_en
      assign en_c[i] = lit && (int'(slot) == NUM_POS - 1 - i);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg      <= '0;
      dig_en   <= '0;
      sign_led <= 1'b0;
      armed    <= 1'b0;
    end else begin
      seg      <= lit ? seg_c : 7'h00;
      dig_en   <= en_c;
      sign_led <= sign_pos;
      armed    <= 1'b1;
    end
  end

  // R2: never more than one position driven
  a_r2_one_digit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dig_en));

  // R3: segments are dark whenever no position is enabled
  a_r3_dark_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (dig_en == 4'b0000) |-> (seg == 7'h00));

  // R7: overflow shows F in the tens position
  a_r7_letter_f: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(ovf) && dig_en[1]) |-> (seg == 7'h71));

  // R6: half-digit position only ever shows "1" or nothing
  a_r6_half_glyph: assert property (@(posedge clk) disable iff (!rst_n)
    dig_en[3] |-> (seg == 7'h06 || seg == 7'h00));

  // R8: polarity indicator follows input one edge later
  a_r8_sign_follow: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (sign_led == $past(sign_pos)));
endmodule

// File: tb/disp_mux_top_bench.sv
`timescale 1ns/1ps
module disp_mux_top_bench;
  localparam int SL = 6;
  localparam int BS = 5;
  localparam int S  = 1 << SL;
  localparam int B  = S >> BS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] bcd_hund = 4'd0, bcd_tens = 4'd0, bcd_ones = 4'd0;
  logic half_one = 1'b0, sign_pos = 1'b0, ovf = 1'b0;
  logic [6:0] seg;
  logic [3:0] dig_en;
  logic sign_led;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  disp_mux_top #(.SLOT_LOG2(SL), .BLANK_SHIFT(BS)) u_disp_mux_top (
    .clk(clk), .rst_n(rst_n), .bcd_hund(bcd_hund), .bcd_tens(bcd_tens),
    .bcd_ones(bcd_ones), .half_one(half_one), .sign_pos(sign_pos), .ovf(ovf),
    .seg(seg), .dig_en(dig_en), .sign_led(sign_led));

  function automatic logic [6:0] num_seg(input int d);
    case (d)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; 9: return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step_inputs();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    bcd_hund = lfsr[3:0];
    bcd_tens = lfsr[7:4];
    bcd_ones = lfsr[11:8];
    half_one = lfsr[12];
    sign_pos = lfsr[14];
    ovf      = (lfsr[15:13] == 3'b000);
  endtask

  // k = number of rising edges since reset release
  task automatic check_cycle(input int k);
    int c, sl, ph, d;
    logic [6:0] es;
    string tag;
    c  = (k - 1) % (4 * S);
    sl = c / S;
    ph = c % S;
    if (ph < B) begin
      check("R3 gap enables", dig_en, 0);
      check("R3 gap segments", seg, 0);
    end else begin
      check("R2 enable order", dig_en, 8 >> sl);
      if (sl == 0) begin
        if (ovf) begin es = 7'h00; tag = "R7 overflow half slot"; end
        else begin es = half_one ? 7'h06 : 7'h00; tag = "R6 half digit"; end
      end else if (ovf) begin
        es = (sl == 1) ? 7'h3F : (sl == 2) ? 7'h71 : 7'h38;
        tag = "R7 overflow letters";
      end else begin
        d = (sl == 1) ? int'(bcd_hund) : (sl == 2) ? int'(bcd_tens) : int'(bcd_ones);
        es = num_seg(d);
        tag = (d > 9) ? "R5 invalid code dark" : "R4 R9 digit decode";
      end
      check(tag, seg, es);
    end
    check("R8 sign indicator", sign_led, sign_pos);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: outputs idle during reset even with live inputs
    bcd_hund = 4'd8; half_one = 1'b1; sign_pos = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset seg", seg, 0);
    check("R1 reset dig_en", dig_en, 0);
    check("R1 reset sign", sign_led, 0);
    rst_n = 1'b1;
    for (int k = 1; k <= 40 * S; k++) begin
      @(negedge clk);
      check_cycle(k);
      step_inputs();
    end
    // R1: asynchronous reset in the middle of a lit slot
    repeat (S + S / 2) @(negedge clk);
    #1 rst_n = 1'b0;
    #1;
    check("R1 async reset seg", seg, 0);
    check("R1 async reset dig_en", dig_en, 0);
    check("R1 async reset sign", sign_led, 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 1; k <= 8 * S; k++) begin
      @(negedge clk);
      check_cycle(k);
      if (k % 3 == 0) step_inputs();
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule